// File: doc/BRIEF.md
# Clock-Slotted Serial Frame Monitor with Break Detection

This block passively observes a two-wire debug link that has a clock line and a shared data line. It never drives the link. Both wires pass through a synchroniser into the fast system clock domain, where their edges are detected. The data line is captured on each rising edge of the link clock. Each falling edge closes one bit slot and hands the captured bit onward.

A frame assembler collects bits into 11-bit frames and checks even parity and the stop bit. It forwards a byte only when the frame is clean.

A separate zero-run counter watches the bit stream without regard to frame alignment. It flags a break once the line has stayed low for a whole frame's worth of slots. The break is reported when the line goes high again. Any half-collected frame is thrown away at that point.

Top module: `lnk_frame_mon`

## Requirements
- R1: The data line is sampled on a rising link-clock edge and a bit slot ends on a falling edge. The first falling edge after reset only arms the slot logic and yields no bit. A data change between the rising and the falling edge has no effect on the bit.
- R2: A frame is a low start bit, eight data bits least significant first, one parity bit and one stop bit. A clean frame produces a one-cycle `byte_vld` with the data on `byte_data`.
- R3: The eight data bits and the parity bit together must hold an even number of ones. Otherwise `par_err` pulses for that frame and no byte is forwarded.
- R4: A stop bit read as 0 pulses `stop_err` for that frame and no byte is forwarded.
- R5: Only one stop bit is expected. Frames sent back to back with one stop bit decode correctly. A second high stop bit is treated as idle.
- R6: While no frame is in progress, high bits are ignored and produce no strobe.
- R7: Consecutive zero bits are counted across frame boundaries, and any one bit clears the count. When the count reaches 11, a break becomes pending. A run of 10 zeros followed by a one is not a break.
- R8: A pending break of any length is reported by a one-cycle `brk_det` only when a one bit arrives. No frame strobe is raised for the bits collected before it, and the next frame decodes from its own start bit.
- R9: All outputs are single-cycle strobes. `par_err` and `stop_err` can pulse in the same cycle for one frame. Neither error strobe ever coincides with `byte_vld`.
- R10: Synchronous active-high reset clears the slot arming, the frame bit count, the zero count, the pending break and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_clk | input | 1 | Observed link clock (asynchronous) |
| link_dat | input | 1 | Observed link data (asynchronous) |
| byte_vld | output | 1 | One-cycle strobe: clean frame received |
| byte_data | output | 8 | Data byte of the clean frame |
| par_err | output | 1 | One-cycle strobe: parity check failed |
| stop_err | output | 1 | One-cycle strobe: stop bit was low |
| brk_det | output | 1 | One-cycle strobe: break ended (line back high) |

## Verification
The parity check and the stop check can both fail on the same frame. The two error strobes must then rise in one cycle, with no byte strobe. The bench provokes this with data 0x03, an odd parity bit and a low stop bit. A monitor sampling between clock edges counts the cycles where both strobes are high together, and it must count exactly one. The bench also runs a truncated frame straight into a long zero run, so that a failing frame and a break come one after the other. It then checks that the errors and the break arrive as separate strobes.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Frame as it sits in the shift register after the last bit (stop on top).
    typedef struct packed {
        logic              stop;
        logic              par;
        logic [DATA_W-1:0] data;
        logic              start;
    } lnk_frame_t;

    typedef struct packed {
        logic              byte_vld;
        logic [DATA_W-1:0] byte_data;
        logic              par_err;
        logic              stop_err;
        logic              brk;
    } lnk_evt_t;

    function automatic logic even_ok(input logic [DATA_W-1:0] d, input logic p);
        return ~(^{d, p});
    endfunction

endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/lnk_slot.sv
module lnk_slot (
    input  logic clk,
    input  logic rst,
    input  logic lclk_s,
    input  logic ldat_s,
    output logic bit_vld,
    output logic bit_val
);
    logic prev_clk, samp, armed;
    logic rise, fall;

    assign rise = lclk_s & ~prev_clk;
    assign fall = ~lclk_s & prev_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            samp     <= 1'b1;
            armed    <= 1'b0;
            bit_vld  <= 1'b0;
            bit_val  <= 1'b1;
        end else begin
            prev_clk <= lclk_s;
            bit_vld  <= 1'b0;
            if (rise) samp <= ldat_s;
            if (fall) begin
                armed <= 1'b1;
                if (armed) begin
                    bit_vld <= 1'b1;
                    bit_val <= samp;
                end
            end
        end
    end

    AST_SLOT_ARMED: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> armed); // R1
    AST_SLOT_PULSE: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld); // R1
endmodule

// File: rtl/lnk_frame.sv
module lnk_frame
    import lnk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_vld,
    input  logic     bit_val,
    output lnk_evt_t evt
);
    logic [FRAME_BITS-1:0] sh, sh_nx;
    logic [CNT_W-1:0]      cnt, zc, zc_nx;
    logic                  pend;
    lnk_frame_t            fr;

    assign sh_nx = {bit_val, sh[FRAME_BITS-1:1]};
    assign fr    = lnk_frame_t'(sh_nx);
    assign zc_nx = bit_val ? '0 :
                   (zc == CNT_W'(FRAME_BITS)) ? zc : zc + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            zc   <= '0;
            pend <= 1'b0;
            evt  <= '0;
        end else begin
            evt.byte_vld <= 1'b0;
            evt.par_err  <= 1'b0;
            evt.stop_err <= 1'b0;
            evt.brk      <= 1'b0;
            if (bit_vld) begin
                zc <= zc_nx;
                if (pend) begin
                    if (bit_val) begin
                        evt.brk <= 1'b1;
                        pend    <= 1'b0;
                        cnt     <= '0;
                    end
                end else if (zc_nx == CNT_W'(FRAME_BITS)) begin
                    pend <= 1'b1;
                    cnt  <= '0;
                end else if (cnt == '0 && bit_val) begin
                    cnt <= '0;
                end else begin
                    sh <= sh_nx;
                    if (cnt == CNT_W'(FRAME_BITS - 1)) begin
                        cnt           <= '0;
                        evt.par_err   <= ~even_ok(fr.data, fr.par);
                        evt.stop_err  <= ~fr.stop;
                        evt.byte_vld  <= even_ok(fr.data, fr.par) & fr.stop;
                        evt.byte_data <= fr.data;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(FRAME_BITS)); // R2
    AST_ZC_RANGE: assert property (@(posedge clk) disable iff (rst)
        zc <= CNT_W'(FRAME_BITS)); // R7
    AST_BYTE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        evt.byte_vld |-> !evt.par_err && !evt.stop_err); // R9
    AST_BRK_ALONE: assert property (@(posedge clk) disable iff (rst)
        evt.brk |-> !evt.byte_vld && !evt.par_err && !evt.stop_err); // R8
    AST_BRK_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        evt.brk |-> $past(pend)); // R8
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt.byte_vld |=> !evt.byte_vld); // R9
endmodule

// File: rtl/lnk_frame_mon.sv
module lnk_frame_mon
    import lnk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_clk,
    input  logic              link_dat,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              par_err,
    output logic              stop_err,
    output logic              brk_det
);
    logic [1:0] sync_q;
    logic       bit_vld, bit_val;
    lnk_evt_t   evt;

    lnk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({link_clk, link_dat}),
        .dout (sync_q)
    );

    lnk_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .lclk_s  (sync_q[1]),
        .ldat_s  (sync_q[0]),
        .bit_vld (bit_vld),
        .bit_val (bit_val)
    );

    lnk_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .evt     (evt)
    );

    assign byte_vld  = evt.byte_vld;
    assign byte_data = evt.byte_data;
    assign par_err   = evt.par_err;
    assign stop_err  = evt.stop_err;
    assign brk_det   = evt.brk;

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (par_err || stop_err) |=> !(par_err || stop_err)); // R9
endmodule

// File: tb/tb_lnk_frame_mon.sv
module tb_lnk_frame_mon;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_clk = 1'b0;
    logic       link_dat = 1'b1;
    logic       byte_vld, par_err, stop_err, brk_det;
    logic [7:0] byte_data;

    int checks = 0, fails = 0;
    int n_byte, n_perr, n_serr, n_brk, n_both;
    logic [7:0] last_byte;
    logic clr = 1'b0;
    bit done = 1'b0;
    localparam int HP = 6;

    always #2.5 clk = ~clk;

    lnk_frame_mon dut (
        .clk(clk), .rst(rst), .link_clk(link_clk), .link_dat(link_dat),
        .byte_vld(byte_vld), .byte_data(byte_data), .par_err(par_err),
        .stop_err(stop_err), .brk_det(brk_det)
    );

    always @(negedge clk) begin
        if (clr) begin
            n_byte = 0; n_perr = 0; n_serr = 0; n_brk = 0; n_both = 0;
        end else if (!rst) begin
            if (byte_vld) begin n_byte++; last_byte = byte_data; end
            if (par_err)  n_perr++;
            if (stop_err) n_serr++;
            if (brk_det)  n_brk++;
            if (par_err && stop_err) n_both++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); clr = 1'b1;
        @(posedge clk); clr = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // One slot: data set, rising edge samples, falling edge closes the slot.
    task automatic send_bit(input logic b, input bit glitch = 0);
        link_dat = b;
        waitc(HP);
        link_clk = 1'b1;
        waitc(HP / 2);
        if (glitch) link_dat = ~b;
        waitc(HP - HP / 2);
        link_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit par_flip,
                              input logic stop, input bit glitch = 0);
        send_bit(1'b0, glitch);
        for (int i = 0; i < 8; i++) send_bit(d[i], glitch);
        send_bit((^d) ^ par_flip, glitch);
        send_bit(stop, glitch);
    endtask

    task automatic t_reset();
        waitc(3);
        @(negedge clk);
        chk("R10 byte_vld", byte_vld, 0);
        chk("R10 errors", par_err | stop_err, 0);
        chk("R10 brk", brk_det, 0);
    endtask

    task automatic t_arm();
        clear_mon();
        send_bit(1'b0);          // first falling edge only arms
        send_bit(1'b1); send_bit(1'b1);
        send_frame(8'h5A, 0, 1'b1);
        waitc(10);
        chk("R1 arm byte count", n_byte, 1);
        chk("R1 arm byte value", last_byte, 8'h5A);
    endtask

    task automatic t_good();
        clear_mon();
        send_frame(8'hA5, 0, 1'b1, 1);
        send_bit(1'b1);
        waitc(10);
        chk("R2 byte count", n_byte, 1);
        chk("R1 R2 value with glitch after rise", last_byte, 8'hA5);
        chk("R2 no errors", n_perr + n_serr, 0);
    endtask

    task automatic t_parity();
        clear_mon();
        send_frame(8'h01, 1, 1'b1);
        send_bit(1'b1);
        waitc(10);
        chk("R3 parity err", n_perr, 1);
        chk("R3 no byte", n_byte, 0);
        chk("R3 no stop err", n_serr, 0);
    endtask

    task automatic t_stop();
        clear_mon();
        send_frame(8'h03, 0, 1'b0);
        send_bit(1'b1); send_bit(1'b1);
        waitc(10);
        chk("R4 stop err", n_serr, 1);
        chk("R4 no byte", n_byte, 0);
        chk("R4 no parity err", n_perr, 0);
    endtask

    task automatic t_both();
        clear_mon();
        send_frame(8'h03, 1, 1'b0);
        send_bit(1'b1); send_bit(1'b1);
        waitc(10);
        chk("R9 both errors same cycle", n_both, 1);
        chk("R9 no byte with errors", n_byte, 0);
    endtask

    task automatic t_stops();
        clear_mon();
        send_frame(8'h11, 0, 1'b1);
        send_frame(8'h22, 0, 1'b1);
        waitc(10);
        chk("R5 back to back one stop", n_byte, 2);
        chk("R5 second value", last_byte, 8'h22);
        clear_mon();
        send_frame(8'h3C, 0, 1'b1);
        send_bit(1'b1);
        send_frame(8'hC3, 0, 1'b1);
        send_bit(1'b1);
        waitc(10);
        chk("R5 two stop bits", n_byte, 2);
        chk("R5 two stop value", last_byte, 8'hC3);
    endtask

    task automatic t_idle();
        clear_mon();
        for (int i = 0; i < 25; i++) send_bit(1'b1);
        waitc(10);
        chk("R6 idle ones", n_byte + n_perr + n_serr + n_brk, 0);
    endtask

    task automatic t_ten_zeros();
        clear_mon();
        for (int i = 0; i < 10; i++) send_bit(1'b0);
        send_bit(1'b1);
        waitc(10);
        chk("R7 ten zeros no break", n_brk, 0);
        chk("R7 ten zeros give byte", n_byte, 1);
        chk("R7 byte value zero", last_byte, 0);
    endtask

    task automatic t_break_exact();
        clear_mon();
        for (int i = 0; i < 11; i++) send_bit(1'b0);
        waitc(10);
        chk("R8 pending not reported while low", n_brk, 0);
        send_bit(1'b1);
        waitc(10);
        chk("R7 break at eleven", n_brk, 1);
        chk("R8 no frame strobe", n_byte + n_perr + n_serr, 0);
        send_frame(8'h6B, 0, 1'b1);
        send_bit(1'b1);
        waitc(10);
        chk("R8 next frame after break", n_byte, 1);
        chk("R8 next value", last_byte, 8'h6B);
    endtask

    task automatic t_break_long();
        clear_mon();
        for (int i = 0; i < 30; i++) send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b1);
        waitc(10);
        chk("R8 long break one strobe", n_brk, 1);
        chk("R8 long break no frame", n_byte + n_perr + n_serr, 0);
    endtask

    task automatic t_break_unaligned();
        clear_mon();
        send_bit(1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        for (int i = 0; i < 14; i++) send_bit(1'b0);
        waitc(10);
        chk("R7 unaligned frame errors first", n_perr + n_serr, 2);
        chk("R8 unaligned pending", n_brk, 0);
        send_bit(1'b1);
        waitc(10);
        chk("R7 unaligned break", n_brk, 1);
        chk("R7 unaligned no byte", n_byte, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        waitc(4);
        t_reset();
        rst = 1'b0;
        waitc(2);
        t_arm();
        t_good();
        t_parity();
        t_stop();
        t_both();
        t_stops();
        t_idle();
        t_ten_zeros();
        t_break_exact();
        t_break_long();
        t_break_unaligned();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule